// File: doc/BRIEF.md
# Banked Second-Level Translation Control Register

This block keeps a 32-bit control word that steers stage-one address translation. It holds two copies of the word, one for the secure world and one for the non-secure world. The block decodes coprocessor-style read and write requests, qualifies them against the current privilege level (0 to 3) and any hypervisor trap controls, and picks the copy that the access reaches. An access is answered in the cycle it is presented. The answer is read data, an undefined-instruction flag, or a trap with its target level, flavour and syndrome code.

The word has two kinds of fields. Each address range (lower and upper) has a hierarchical-permission disable. Each range also has four hardware-use enables, one for each of leaf-entry bits 59 to 62. The block does not pass the stored fields to the translation logic directly. It first gates each one by the extended-format enable, and gates the hardware-use enables a second time by their own range's permission disable. The table walker reads these effective vectors from whichever copy the current world translates with.

Top module: `xlat_ctl2_bank`

## Requirements
- R1: After reset both copies hold zero, and a read of either copy returns 0x00000000.
- R2: A request reaches the register only when the coprocessor number is 15, op1 is 0, CRn is 2, CRm is 0 and op2 is 3. Any other request produces no undefined flag, no trap and zero read data, and changes no copy.
- R3: Bits 31:19 and 8:0 always read as zero, and writes to them are discarded. Bit 10 is the upper-range permission disable. Bit 9 is the lower-range permission disable. Bits 18:15 are the upper-range hardware-use enables and bits 14:11 are the lower-range ones. In each group the lowest bit gates leaf bit 59 and the highest gates leaf bit 62.
- R4: While `feat_hwuse` is low, bits 18:11 read as zero and writes to them are not stored.
- R5: A matching request at level 0, or any matching request while `feat_base` is low, raises `undef`, returns zero data and changes no copy.
- R6: At level 1 with `lvl2_on` high, the group trap bit traps both reads and writes. If it is clear, `trap_vm_rd` traps reads and `trap_vm_wr` traps writes. A trap sets `trap_lvl`=2 and `trap_code`=0x03, and sets `trap_wide` when `lvl2_narrow` is low. No trap is raised when `lvl2_on` is low or when the request is at level 2.
- R7: At levels 1 and 2 the access reaches the non-secure copy. When `lvl3_here` and `lvl3_narrow` are not both high, banking is off and that same copy is the single common copy.
- R8: At level 3, `world_ns`=0 selects the secure copy and `world_ns`=1 selects the non-secure copy.
- R9: A write at level 3 with `world_ns`=0 raises `undef` and changes nothing when `sec_lock_a` or `sec_lock_b` is high. Reads and non-secure writes are not affected by these inputs.
- R10: Each effective permission disable equals its stored bit ANDed with `ext_fmt_en`.
- R11: Each effective hardware-use enable equals its stored bit ANDed with its range's stored permission disable and with `ext_fmt_en`.
- R12: The effective vectors come from the secure copy when banking is on and `world_ns`=0. Otherwise they come from the non-secure copy.
- R13: Read data, `undef` and trap outputs are valid in the request cycle. An accepted write is visible from the next cycle. A trapped or undefined access leaves both copies unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cp | input | 4 | Coprocessor number |
| req_op1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_op2 | input | 3 | Second opcode field |
| req_wdata | input | 32 | Write data |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| world_ns | input | 1 | Security state at level 3 (1 = non-secure) |
| lvl2_on | input | 1 | Level 2 enabled |
| lvl2_narrow | input | 1 | Level 2 runs the 32-bit state |
| lvl3_here | input | 1 | Level 3 implemented |
| lvl3_narrow | input | 1 | Level 3 runs the 32-bit state |
| trap_grp2 | input | 1 | Group trap control for this register |
| trap_vm_rd | input | 1 | Read trap for virtual-memory controls |
| trap_vm_wr | input | 1 | Write trap for virtual-memory controls |
| sec_lock_a | input | 1 | First secure-configuration write lock |
| sec_lock_b | input | 1 | Second secure-configuration write lock |
| ext_fmt_en | input | 1 | Extended translation format enable |
| feat_base | input | 1 | Strap: register present |
| feat_hwuse | input | 1 | Strap: hardware-use fields present |
| rd_data | output | 32 | Read data (zero unless an accepted read) |
| undef | output | 1 | Undefined-instruction result |
| trap | output | 1 | Trap result |
| trap_lvl | output | 2 | Trap target level |
| trap_wide | output | 1 | Trap is of the 64-bit flavour |
| trap_code | output | 6 | Trap syndrome code |
| eff_hier_lo | output | 1 | Effective lower-range permission disable |
| eff_hier_hi | output | 1 | Effective upper-range permission disable |
| eff_hw_lo | output | 4 | Effective lower-range hardware-use enables (bit k gates leaf bit 59+k) |
| eff_hw_hi | output | 4 | Effective upper-range hardware-use enables (bit k gates leaf bit 59+k) |

## Verification
Two things can share a cycle: answering a request and presenting the effective vectors. A write can also coincide with a trap or lock, and the rejection must win over the store. The bench provokes this with writes of all-ones data while the group trap, a read/write trap or a secure lock is raised. It then reads the copy back through a path that is not trapped, and checks that the stored value and the effective vectors have not moved. It also changes the world flag and the banking controls between reads. This confirms that the effective vectors follow the copy in use for translation, whichever copy the last access reached.

// File: rtl/xlat_ctl2_pkg.sv
package xlat_ctl2_pkg;
  localparam int CTL_W     = 32;
  localparam int HW_N      = 4;
  localparam int HIER_LO   = 9;
  localparam int HIER_HI   = 10;
  localparam int HW_LO_LSB = 11;
  localparam int HW_HI_LSB = 15;
  localparam int NBANK     = 2;

  localparam logic [3:0] ENC_CP  = 4'd15;
  localparam logic [2:0] ENC_OP1 = 3'd0;
  localparam logic [3:0] ENC_CRN = 4'd2;
  localparam logic [3:0] ENC_CRM = 4'd0;
  localparam logic [2:0] ENC_OP2 = 3'd3;

  localparam logic [5:0] TRAP_SYN = 6'h03;
  localparam logic [1:0] TRAP_TGT = 2'd2;

  localparam logic BANK_SEC = 1'b0;
  localparam logic BANK_NS  = 1'b1;

  typedef enum logic [1:0] {LVL_USER = 2'd0, LVL_OS = 2'd1, LVL_HYP = 2'd2, LVL_MON = 2'd3} lvl_e;

  typedef struct packed {
    logic undef;
    logic trap;
    logic wide;
    logic wr_en;
    logic rd_en;
    logic bank;
  } acc_res_t;

  function automatic logic [CTL_W-1:0] live_mask(input logic hw_present);
    logic [CTL_W-1:0] m;
    m = '0;
    m[HIER_LO] = 1'b1;
    m[HIER_HI] = 1'b1;
    m[HW_LO_LSB +: HW_N] = {HW_N{hw_present}};
    m[HW_HI_LSB +: HW_N] = {HW_N{hw_present}};
    return m;
  endfunction
endpackage

// File: rtl/xlat_ctl2_access.sv
module xlat_ctl2_access
  import xlat_ctl2_pkg::*;
(
  input  logic       hit,
  input  logic       is_wr,
  input  logic [1:0] lvl,
  input  logic       world_ns,
  input  logic       lvl2_on,
  input  logic       lvl2_narrow,
  input  logic       trap_grp2,
  input  logic       trap_vm_rd,
  input  logic       trap_vm_wr,
  input  logic       sec_lock,
  input  logic       feat_base,
  output acc_res_t   res
);
  logic vm_hit;

  always_comb begin
    vm_hit = is_wr ? trap_vm_wr : trap_vm_rd;
    res = '0;
    res.bank = BANK_NS;
    if (hit) begin
      if (!feat_base || lvl_e'(lvl) == LVL_USER) begin
        res.undef = 1'b1;
      end else if (lvl_e'(lvl) == LVL_OS) begin
        // group trap is checked ahead of the virtual-memory traps
        if (lvl2_on && trap_grp2) begin
          res.trap = 1'b1;
        end else if (lvl2_on && vm_hit) begin
          res.trap = 1'b1;
        end
        res.wide = res.trap & ~lvl2_narrow;
      end else if (lvl_e'(lvl) == LVL_MON) begin
        res.bank  = world_ns ? BANK_NS : BANK_SEC;
        res.undef = is_wr & ~world_ns & sec_lock;
      end
      res.wr_en = is_wr  & ~res.undef & ~res.trap;
      res.rd_en = ~is_wr & ~res.undef & ~res.trap;
    end
  end
endmodule

// File: rtl/xlat_ctl2_store.sv
module xlat_ctl2_store #(
  parameter int REG_W = 32,
  parameter int NB    = 2,
  localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [REG_W-1:0]          wr_data,
  input  logic [REG_W-1:0]          wr_mask,
  output logic [NB-1:0][REG_W-1:0]  bank_q
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic             ld;
    logic [REG_W-1:0] nxt;

    always_comb begin
      ld  = wr_en && (wr_sel == SEL_W'(b));
      nxt = wr_data & wr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[b] <= '0;
      end else if (ld) begin
        bank_q[b] <= nxt;
      end
    end
  end
endmodule

// File: rtl/xlat_ctl2_effective.sv
module xlat_ctl2_effective #(
  parameter int REG_W   = 32,
  parameter int HWN     = 4,
  parameter int H_LO    = 9,
  parameter int H_HI    = 10,
  parameter int HW_LO   = 11,
  parameter int HW_HI   = 15
) (
  input  logic [REG_W-1:0] word,
  input  logic             ext_en,
  output logic [1:0]       hier,
  output logic [1:0][HWN-1:0] hw
);
  for (genvar r = 0; r < 2; r++) begin : g_range
    localparam int HP = (r == 0) ? H_LO : H_HI;
    localparam int HL = (r == 0) ? HW_LO : HW_HI;
    always_comb begin
      hier[r] = word[HP] & ext_en;
      hw[r]   = word[HL +: HWN] & {HWN{hier[r]}};
    end
  end
endmodule

// File: rtl/xlat_ctl2_bank.sv
module xlat_ctl2_bank
  import xlat_ctl2_pkg::*;
#(
  parameter int REG_W = CTL_W,
  parameter int HWN   = HW_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [3:0]       req_cp,
  input  logic [2:0]       req_op1,
  input  logic [3:0]       req_crn,
  input  logic [3:0]       req_crm,
  input  logic [2:0]       req_op2,
  input  logic [REG_W-1:0] req_wdata,
  input  logic [1:0]       cur_lvl,
  input  logic             world_ns,
  input  logic             lvl2_on,
  input  logic             lvl2_narrow,
  input  logic             lvl3_here,
  input  logic             lvl3_narrow,
  input  logic             trap_grp2,
  input  logic             trap_vm_rd,
  input  logic             trap_vm_wr,
  input  logic             sec_lock_a,
  input  logic             sec_lock_b,
  input  logic             ext_fmt_en,
  input  logic             feat_base,
  input  logic             feat_hwuse,
  output logic [REG_W-1:0] rd_data,
  output logic             undef,
  output logic             trap,
  output logic [1:0]       trap_lvl,
  output logic             trap_wide,
  output logic [5:0]       trap_code,
  output logic             eff_hier_lo,
  output logic             eff_hier_hi,
  output logic [HWN-1:0]   eff_hw_lo,
  output logic [HWN-1:0]   eff_hw_hi
);
  logic [1:0]                  rst_pipe;
  logic                        rst_sync_n;
  logic                        enc_hit;
  logic                        banked;
  logic [REG_W-1:0]            mask;
  logic                        xl_bank;
  logic [REG_W-1:0]            xl_word;
  logic [1:0]                  hier_v;
  logic [1:0][HWN-1:0]         hw_v;
  logic [NBANK-1:0][REG_W-1:0] st_q;
  acc_res_t                    res;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    enc_hit = req_valid && req_cp == ENC_CP && req_op1 == ENC_OP1 &&
              req_crn == ENC_CRN && req_crm == ENC_CRM && req_op2 == ENC_OP2;
    banked  = lvl3_here & lvl3_narrow;
    mask    = live_mask(feat_hwuse);
  end

  xlat_ctl2_access u_acc (
    .hit        (enc_hit),
    .is_wr      (req_write),
    .lvl        (cur_lvl),
    .world_ns   (world_ns),
    .lvl2_on    (lvl2_on),
    .lvl2_narrow(lvl2_narrow),
    .trap_grp2  (trap_grp2),
    .trap_vm_rd (trap_vm_rd),
    .trap_vm_wr (trap_vm_wr),
    .sec_lock   (sec_lock_a | sec_lock_b),
    .feat_base  (feat_base),
    .res        (res)
  );

  xlat_ctl2_store #(.REG_W(REG_W), .NB(NBANK)) u_store (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (res.wr_en),
    .wr_sel (res.bank),
    .wr_data(req_wdata),
    .wr_mask(mask),
    .bank_q (st_q)
  );

  always_comb begin
    rd_data   = res.rd_en ? (st_q[res.bank] & mask) : '0;
    undef     = res.undef;
    trap      = res.trap;
    trap_wide = res.wide;
    trap_lvl  = res.trap ? TRAP_TGT : 2'd0;
    trap_code = res.trap ? TRAP_SYN : 6'd0;
    xl_bank   = (banked && !world_ns) ? BANK_SEC : BANK_NS;
    xl_word   = st_q[xl_bank] & mask;
  end

  xlat_ctl2_effective #(
    .REG_W(REG_W), .HWN(HWN), .H_LO(HIER_LO), .H_HI(HIER_HI),
    .HW_LO(HW_LO_LSB), .HW_HI(HW_HI_LSB)
  ) u_eff (
    .word  (xl_word),
    .ext_en(ext_fmt_en),
    .hier  (hier_v),
    .hw    (hw_v)
  );

  always_comb begin
    eff_hier_lo = hier_v[0];
    eff_hier_hi = hier_v[1];
    eff_hw_lo   = hw_v[0];
    eff_hw_hi   = hw_v[1];
  end
endmodule

// File: rtl/xlat_ctl2_chk.sv
module xlat_ctl2_chk #(
  parameter int REG_W = 32,
  parameter int HWN   = 4,
  parameter int NB    = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [3:0]               req_cp,
  input logic [2:0]               req_op1,
  input logic [3:0]               req_crn,
  input logic [3:0]               req_crm,
  input logic [2:0]               req_op2,
  input logic [1:0]               cur_lvl,
  input logic                     feat_base,
  input logic                     lvl2_on,
  input logic                     lvl2_narrow,
  input logic                     ext_fmt_en,
  input logic [REG_W-1:0]         rd_data,
  input logic                     undef,
  input logic                     trap,
  input logic [1:0]               trap_lvl,
  input logic                     trap_wide,
  input logic [5:0]               trap_code,
  input logic                     eff_hier_lo,
  input logic                     eff_hier_hi,
  input logic [HWN-1:0]           eff_hw_lo,
  input logic [HWN-1:0]           eff_hw_hi,
  input logic [NB-1:0][REG_W-1:0] st_q
);
  logic sel;
  assign sel = req_valid && req_cp == 4'd15 && req_op1 == 3'd0 &&
               req_crn == 4'd2 && req_crm == 4'd0 && req_op2 == 3'd3;

  assert_quiet_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!undef && !trap && rd_data == '0));

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[REG_W-1:19] == '0 && rd_data[8:0] == '0));

  assert_user_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && (cur_lvl == 2'd0 || !feat_base)) |-> (undef && !trap));

  assert_trap_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (trap_lvl == 2'd2 && trap_code == 6'h03 && trap_wide == !lvl2_narrow
              && cur_lvl == 2'd1 && lvl2_on));

  assert_ext_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_fmt_en |-> (!eff_hier_lo && !eff_hier_hi && eff_hw_lo == '0 && eff_hw_hi == '0));

  assert_hw_needs_hier_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((eff_hw_lo != '0) |-> eff_hier_lo) and ((eff_hw_hi != '0) |-> eff_hier_hi));

  assert_hold_on_reject_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (undef || trap) |=> $stable(st_q));
endmodule

bind xlat_ctl2_bank xlat_ctl2_chk #(.REG_W(REG_W), .HWN(HWN), .NB(xlat_ctl2_pkg::NBANK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_cp     (req_cp),
  .req_op1    (req_op1),
  .req_crn    (req_crn),
  .req_crm    (req_crm),
  .req_op2    (req_op2),
  .cur_lvl    (cur_lvl),
  .feat_base  (feat_base),
  .lvl2_on    (lvl2_on),
  .lvl2_narrow(lvl2_narrow),
  .ext_fmt_en (ext_fmt_en),
  .rd_data    (rd_data),
  .undef      (undef),
  .trap       (trap),
  .trap_lvl   (trap_lvl),
  .trap_wide  (trap_wide),
  .trap_code  (trap_code),
  .eff_hier_lo(eff_hier_lo),
  .eff_hier_hi(eff_hier_hi),
  .eff_hw_lo  (eff_hw_lo),
  .eff_hw_hi  (eff_hw_hi),
  .st_q       (st_q)
);

// File: tb/xlat_ctl2_bank_test.sv
module xlat_ctl2_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [3:0]  req_cp, req_crn, req_crm;
  logic [2:0]  req_op1, req_op2;
  logic [31:0] req_wdata;
  logic [1:0]  cur_lvl;
  logic world_ns, lvl2_on, lvl2_narrow, lvl3_here, lvl3_narrow;
  logic trap_grp2, trap_vm_rd, trap_vm_wr, sec_lock_a, sec_lock_b;
  logic ext_fmt_en, feat_base, feat_hwuse;
  logic [31:0] rd_data;
  logic        undef, trap, trap_wide, eff_hier_lo, eff_hier_hi;
  logic [1:0]  trap_lvl;
  logic [5:0]  trap_code;
  logic [3:0]  eff_hw_lo, eff_hw_hi;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] s_rd;
  logic        s_un, s_tr, s_wide;
  logic [1:0]  s_tlvl;
  logic [5:0]  s_code;

  localparam logic [31:0] SEC_V = 32'h0001_2A00;

  always #4 clk = ~clk;

  xlat_ctl2_bank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cp(req_cp), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
    .req_op2(req_op2), .req_wdata(req_wdata), .cur_lvl(cur_lvl), .world_ns(world_ns),
    .lvl2_on(lvl2_on), .lvl2_narrow(lvl2_narrow), .lvl3_here(lvl3_here),
    .lvl3_narrow(lvl3_narrow), .trap_grp2(trap_grp2), .trap_vm_rd(trap_vm_rd),
    .trap_vm_wr(trap_vm_wr), .sec_lock_a(sec_lock_a), .sec_lock_b(sec_lock_b),
    .ext_fmt_en(ext_fmt_en), .feat_base(feat_base), .feat_hwuse(feat_hwuse),
    .rd_data(rd_data), .undef(undef), .trap(trap), .trap_lvl(trap_lvl),
    .trap_wide(trap_wide), .trap_code(trap_code), .eff_hier_lo(eff_hier_lo),
    .eff_hier_hi(eff_hier_hi), .eff_hw_lo(eff_hw_lo), .eff_hw_hi(eff_hw_hi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_eff(input logic [31:0] s, input logic ext);
    logic hl, hh;
    hl = s[9] & ext;
    hh = s[10] & ext;
    return {hh, hl, s[18:15] & {4{hh}}, s[14:11] & {4{hl}}};
  endfunction

  task automatic acc(input logic w, input logic [1:0] lvl, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; cur_lvl = lvl; req_wdata = d;
    #1;
    s_rd = rd_data; s_un = undef; s_tr = trap;
    s_wide = trap_wide; s_tlvl = trap_lvl; s_code = trap_code;
    @(posedge clk);
    #1 req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic chk_eff(input string tag, input logic [31:0] s);
    @(negedge clk); #1;
    chk(tag, {22'd0, eff_hier_hi, eff_hier_lo, eff_hw_hi, eff_hw_lo},
        {22'd0, exp_eff(s, ext_fmt_en)});
  endtask

  task automatic t_reset;
    world_ns = 1'b0; acc(1'b0, 2'd3, 32'd0);
    chk("R1 secure copy after reset", s_rd, 32'd0);
    world_ns = 1'b1; acc(1'b0, 2'd3, 32'd0);
    chk("R1 non-secure copy after reset", s_rd, 32'd0);
  endtask

  task automatic t_rw_mask;
    acc(1'b1, 2'd1, 32'hFFFF_FFFF);
    chk("R13 accepted write flags", {30'd0, s_un, s_tr}, 32'd0);
    acc(1'b0, 2'd1, 32'd0);
    chk("R3 reserved bits masked", s_rd, 32'h0007_FE00);
    world_ns = 1'b1; acc(1'b0, 2'd3, 32'd0);
    chk("R7 level1 reaches non-secure copy", s_rd, 32'h0007_FE00);
    world_ns = 1'b0; acc(1'b0, 2'd3, 32'd0);
    chk("R8 secure copy untouched", s_rd, 32'd0);
    world_ns = 1'b1;
  endtask

  task automatic t_decode;
    req_op2 = 3'd2; acc(1'b1, 2'd1, 32'd0);
    chk("R2 miss write no result", {s_rd[30:0], s_un, s_tr} , 33'd0);
    req_op2 = 3'd3; req_cp = 4'd14; acc(1'b0, 2'd0, 32'd0);
    chk("R2 miss at level0 no undef", {30'd0, s_un, s_tr}, 32'd0);
    req_cp = 4'd15; acc(1'b0, 2'd1, 32'd0);
    chk("R2 miss changed nothing", s_rd, 32'h0007_FE00);
  endtask

  task automatic t_feat_hw;
    acc(1'b1, 2'd1, 32'd0);
    feat_hwuse = 1'b0; acc(1'b1, 2'd1, 32'hFFFF_FFFF);
    acc(1'b0, 2'd1, 32'd0);
    chk("R4 hw fields read zero when absent", s_rd, 32'h0000_0600);
    feat_hwuse = 1'b1; acc(1'b0, 2'd1, 32'd0);
    chk("R4 hw fields not stored when absent", s_rd, 32'h0000_0600);
  endtask

  task automatic t_undef;
    acc(1'b0, 2'd0, 32'd0);
    chk("R5 level0 read undef", {s_rd[30:0], s_un}, 32'd1);
    acc(1'b1, 2'd0, 32'd0);
    chk("R5 level0 write undef", {31'd0, s_un}, 32'd1);
    feat_base = 1'b0; acc(1'b1, 2'd2, 32'd0);
    chk("R5 base strap absent undef", {31'd0, s_un}, 32'd1);
    feat_base = 1'b1; acc(1'b0, 2'd2, 32'd0);
    chk("R13 undef writes left copy", s_rd, 32'h0000_0600);
  endtask

  task automatic t_trap;
    lvl2_on = 1'b1; lvl2_narrow = 1'b0; trap_grp2 = 1'b1;
    acc(1'b0, 2'd1, 32'd0);
    chk("R6 group trap on read", {s_rd[22:0], s_tr, s_wide, s_tlvl, s_code},
        {23'd0, 1'b1, 1'b1, 2'd2, 6'h03});
    acc(1'b1, 2'd1, 32'hFFFF_FFFF);
    chk("R6 group trap on write", {31'd0, s_tr}, 32'd1);
    acc(1'b0, 2'd2, 32'd0);
    chk("R6 level2 not trapped, R13 copy held", {s_rd[30:0], s_tr}, {32'h0000_0600, 1'b0});
    trap_grp2 = 1'b0; trap_vm_rd = 1'b1;
    acc(1'b1, 2'd1, 32'h0000_0200);
    chk("R6 read trap spares writes", {31'd0, s_tr}, 32'd0);
    acc(1'b0, 2'd1, 32'd0);
    chk("R6 read trap hits reads", {s_rd[30:0], s_tr}, 32'd1);
    trap_vm_rd = 1'b0; trap_vm_wr = 1'b1; lvl2_narrow = 1'b1;
    acc(1'b0, 2'd1, 32'd0);
    chk("R6 write trap spares reads", {s_rd[30:0], s_tr}, {32'h0000_0200, 1'b0});
    acc(1'b1, 2'd1, 32'h0000_0400);
    chk("R6 write trap narrow flavour", {30'd0, s_tr, s_wide}, 32'b10);
    acc(1'b0, 2'd2, 32'd0);
    chk("R13 trapped write left copy", s_rd, 32'h0000_0200);
    lvl2_on = 1'b0; trap_grp2 = 1'b1; trap_vm_rd = 1'b1;
    acc(1'b1, 2'd1, 32'h0000_0400);
    chk("R6 no trap when level2 off", {31'd0, s_tr}, 32'd0);
    trap_grp2 = 1'b0; trap_vm_rd = 1'b0; trap_vm_wr = 1'b0;
  endtask

  task automatic t_bank;
    world_ns = 1'b0; acc(1'b1, 2'd3, SEC_V);
    acc(1'b0, 2'd3, 32'd0);
    chk("R8 secure copy write/read", s_rd, SEC_V);
    world_ns = 1'b1; acc(1'b0, 2'd3, 32'd0);
    chk("R8 non-secure copy separate", s_rd, 32'h0000_0400);
    lvl3_narrow = 1'b0; acc(1'b1, 2'd2, 32'h0000_0600);
    acc(1'b0, 2'd3, 32'd0);
    chk("R7 common copy is non-secure slot", s_rd, 32'h0000_0600);
    lvl3_narrow = 1'b1; world_ns = 1'b0; acc(1'b0, 2'd3, 32'd0);
    chk("R7 secure copy kept", s_rd, SEC_V);
  endtask

  task automatic t_lock;
    world_ns = 1'b0; sec_lock_a = 1'b1; acc(1'b1, 2'd3, 32'd0);
    chk("R9 lock a blocks secure write", {31'd0, s_un}, 32'd1);
    sec_lock_a = 1'b0; sec_lock_b = 1'b1; acc(1'b1, 2'd3, 32'd0);
    chk("R9 lock b blocks secure write", {31'd0, s_un}, 32'd1);
    acc(1'b0, 2'd3, 32'd0);
    chk("R9 secure read allowed and unchanged", {s_rd[30:0], s_un}, {SEC_V[30:0], 1'b0});
    sec_lock_a = 1'b1; world_ns = 1'b1; acc(1'b1, 2'd3, 32'h0007_FE00);
    chk("R9 non-secure write unaffected", {31'd0, s_un}, 32'd0);
    acc(1'b0, 2'd3, 32'd0);
    chk("R9 non-secure write stored", s_rd, 32'h0007_FE00);
    sec_lock_a = 1'b0; sec_lock_b = 1'b0;
  endtask

  task automatic t_eff;
    world_ns = 1'b1;
    chk_eff("R10 R11 full non-secure effective", 32'h0007_FE00);
    ext_fmt_en = 1'b0;
    chk_eff("R10 ext format off gates all", 32'h0007_FE00);
    ext_fmt_en = 1'b1; world_ns = 1'b0;
    chk_eff("R12 secure copy drives effective", SEC_V);
    lvl3_narrow = 1'b0;
    chk_eff("R12 banking off uses non-secure", 32'h0007_FE00);
    lvl3_narrow = 1'b1; world_ns = 1'b1;
    acc(1'b1, 2'd1, 32'h0007_F800);
    chk_eff("R11 hw enables need hier disable", 32'h0007_F800);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_cp = 4'd15; req_op1 = 3'd0; req_crn = 4'd2; req_crm = 4'd0; req_op2 = 3'd3;
    req_wdata = '0; cur_lvl = 2'd1; world_ns = 1'b1;
    lvl2_on = 1'b0; lvl2_narrow = 1'b1; lvl3_here = 1'b1; lvl3_narrow = 1'b1;
    trap_grp2 = 1'b0; trap_vm_rd = 1'b0; trap_vm_wr = 1'b0;
    sec_lock_a = 1'b0; sec_lock_b = 1'b0;
    ext_fmt_en = 1'b1; feat_base = 1'b1; feat_hwuse = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset;
    t_rw_mask;
    t_decode;
    t_feat_hw;
    t_undef;
    t_trap;
    t_bank;
    t_lock;
    t_rw_mask_restore;
    t_eff;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic t_rw_mask_restore;
    world_ns = 1'b1; acc(1'b0, 2'd1, 32'd0);
    chk("R13 read returns last accepted write", s_rd, 32'h0007_FE00);
  endtask
endmodule